// File: doc/BRIEF.md
# Phase-Shift Bridge Gate Sequencer

This block produces the four gate-drive enables of a resonant lamp inverter. A digital ramp counter plays the part of the timing capacitor. It counts one half of the switching period. Each time it restarts it flips the main phase. The first leg (gate_a high side, gate_b low side) follows the main phase. The second leg (gate_c high side, gate_d low side) follows a lagged copy of that phase. The lag is set by an overlap demand word, so the demand controls how long the diagonal switches conduct together.

Every turn-on inside a leg waits a fixed dead time after the other side of that leg turns off. In push-pull topology only the first leg switches. A zero-crossing strobe from the resonant tank can end a half period early, which locks the switching to the tank. A floor on the half-period length caps the frequency that this locking can reach. During striking the block runs at its own fixed half period and ignores both the strobe and the burst-dimming input. An under-voltage inhibit forces all outputs low.

Top module: `psb_gate_seq`

## Requirements
- R1: While rst is high all four gates are low. After rst falls with the block enabled, gate_a is the first output to go high, on the (DEAD_CYC+1)-th rising edge after release.
- R2: gate_a and gate_b are never high together, and neither are gate_c and gate_d. Whenever one side of a leg turns on after the other side turns off, both sides of that leg are low for exactly DEAD_CYC clock cycles in between.
- R3: A half period lasts h clock cycles, where h is the selected half-period input (half_norm, or half_strike during striking). The main phase starts at 0 and alternates between halves. Phase 0 drives gate_a and phase 1 drives gate_b, each one cycle after the phase change, and each side conducts for h-DEAD_CYC cycles.
- R4: In full-bridge mode the second leg lags the first by h-v cycles. Here v = min(ovl_dem, floor(h*115/128)). gate_d conducts in the same half as gate_a, and gate_c in the same half as gate_b. As a result the gate_a/gate_d overlap is max(v-DEAD_CYC,0) cycles per period. A demand of 0 gives no diagonal overlap, and about 90% of the half period is the ceiling.
- R5: With fb_mode=0 (push-pull), gate_c and gate_d are low from the next clock edge on, and the first leg is unaffected. With fb_mode=1 (full-bridge) all four switch.
- R6: Outside striking, a one-cycle sense_zc strobe ends the current half at that edge, provided the half has then lasted at least half_floor cycles (ramp count + 1 >= half_floor). The phase then flips and the ramp restarts.
- R7: A sense_zc strobe that arrives before the half has lasted half_floor cycles has no effect on the outputs.
- R8: While strike is high, the half period is half_strike and sense_zc has no effect.
- R9: Outside striking, burst_on=0 forces all gates low from the next edge and holds the ramp at its start. When burst_on returns to 1, switching restarts from phase 0, with the first turn-on delayed as in R1. While strike is high, burst_on is ignored.
- R10: While uv_lock is high, all gates are low from the next edge. On release the block restarts as in R9.
- R11: The half period, the floor-independent overlap demand and the topology-independent lag are sampled only when a half starts (or while the block is held idle). A change in the middle of a half first takes effect at the next half boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fb_mode | input | 1 | 1 = full-bridge, 0 = push-pull |
| strike | input | 1 | Striking (ignition) mode |
| burst_on | input | 1 | Burst-dimming gate, 1 = switching allowed |
| uv_lock | input | 1 | Under-voltage inhibit, 1 = all gates low |
| sense_zc | input | 1 | One-cycle zero-crossing strobe |
| half_norm | input | CW | Half period in normal mode, clock cycles |
| half_strike | input | CW | Half period during striking, clock cycles |
| half_floor | input | CW | Shortest half period a strobe may end |
| ovl_dem | input | CW | Diagonal overlap demand, clock cycles |
| gate_a | output | 1 | Leg 1 high-side enable |
| gate_b | output | 1 | Leg 1 low-side enable |
| gate_c | output | 1 | Leg 2 high-side enable |
| gate_d | output | 1 | Leg 2 low-side enable |

## Verification
Suppose the ramp count or the sampled half period goes wrong. Then the gates flip one or more cycles too early or too late, and this shows within the same half period. A wrong lag register shifts the gate_c/gate_d edges against gate_a/gate_b and changes the diagonal overlap count in the very next period. A dead-time counter that is off by one lengthens or shortens the all-low gap of a leg at its next side change. A stuck enable path shows at the edge after burst_on, uv_lock or fb_mode changes. The bench therefore compares all four gates against a reference model on every cycle. It also counts conduction and overlap cycles over full periods.

// File: rtl/psb_pkg.sv
package psb_pkg;
  typedef struct packed {
    logic hi;
    logic lo;
  } leg_drv_t;

  typedef enum logic {
    SIDE_HI = 1'b0,
    SIDE_LO = 1'b1
  } side_e;
endpackage

// File: rtl/psb_shift_calc.sv
// Lag of the second leg: half period minus the clipped overlap demand.
module psb_shift_calc #(
  parameter int CW  = 12,
  parameter int OVN = 115,
  parameter int OVS = 7
) (
  input  logic [CW-1:0] half,
  input  logic [CW-1:0] dem,
  output logic [CW-1:0] lag
);
  localparam int PW = CW + OVS;

  logic [PW-1:0] prod;
  logic [PW-1:0] prod_sh;
  logic [CW-1:0] ov_max;
  logic [CW-1:0] ov;

  always_comb begin
    prod    = PW'(half) * PW'(OVN);
    prod_sh = prod >> OVS;
    ov_max  = CW'(prod_sh);
    ov      = (dem < ov_max) ? dem : ov_max;
    lag     = half - ov;
  end
endmodule

// File: rtl/psb_ramp.sv
// Half-period ramp with zero-crossing restart, floor clamp and lagged phase.
module psb_ramp #(
  parameter int CW  = 12,
  parameter int OVN = 115,
  parameter int OVS = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          strike,
  input  logic          zc,
  input  logic [CW-1:0] half_norm,
  input  logic [CW-1:0] half_strike,
  input  logic [CW-1:0] half_floor,
  input  logic [CW-1:0] dem,
  output logic          ph_main,
  output logic          ph_lag
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] half_q;
  logic [CW-1:0] lag_q;
  logic          ph_q;
  logic [CW-1:0] half_sel;
  logic [CW-1:0] lag_nxt;
  logic [CW:0]   cnt_inc;
  logic          wrap;
  logic          sync_ok;

  assign half_sel = strike ? half_strike : half_norm;

  psb_shift_calc #(.CW(CW), .OVN(OVN), .OVS(OVS)) shift_i (
    .half (half_sel),
    .dem  (dem),
    .lag  (lag_nxt)
  );

  always_comb begin
    cnt_inc = {1'b0, cnt_q} + (CW+1)'(1);
    wrap    = (cnt_inc >= {1'b0, half_q});
    sync_ok = !strike && zc && (cnt_inc >= {1'b0, half_floor});
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q  <= '0;
      ph_q   <= 1'b0;
      half_q <= half_sel;
      lag_q  <= lag_nxt;
    end else if (wrap || sync_ok) begin
      cnt_q  <= '0;
      ph_q   <= ~ph_q;
      half_q <= half_sel;
      lag_q  <= lag_nxt;
    end else begin
      cnt_q  <= cnt_inc[CW-1:0];
    end
  end

  assign ph_main = ph_q;
  assign ph_lag  = (cnt_q >= lag_q) ? ph_q : ~ph_q;
endmodule

// File: rtl/psb_deadband.sv
// One bridge leg: registered complementary enables with dead time.
module psb_deadband
  import psb_pkg::*;
#(
  parameter int DEAD_CYC = 6
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     run,
  input  logic     want,
  output leg_drv_t drv
);
  localparam int DW = $clog2(DEAD_CYC + 1);
  localparam logic [DW-1:0] IDLE_LD = DW'(DEAD_CYC);
  localparam logic [DW-1:0] SWAP_LD = DW'(DEAD_CYC - 1);

  side_e         side_q;
  logic [DW-1:0] dc_q;
  leg_drv_t      drv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      side_q <= SIDE_HI;
      dc_q   <= IDLE_LD;
      drv_q  <= '0;
    end else if (!run) begin
      side_q <= side_e'(want);
      dc_q   <= IDLE_LD;
      drv_q  <= '0;
    end else if (side_e'(want) != side_q) begin
      side_q <= side_e'(want);
      dc_q   <= SWAP_LD;
      drv_q  <= '0;
    end else if (dc_q != '0) begin
      dc_q   <= dc_q - DW'(1);
      drv_q  <= '0;
    end else begin
      drv_q.hi <= (side_q == SIDE_HI);
      drv_q.lo <= (side_q == SIDE_LO);
    end
  end

  assign drv = drv_q;
endmodule

// File: rtl/psb_gate_seq.sv
module psb_gate_seq
  import psb_pkg::*;
#(
  parameter int CW       = 12,
  parameter int DEAD_CYC = 6,
  parameter int OVN      = 115,
  parameter int OVS      = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fb_mode,
  input  logic          strike,
  input  logic          burst_on,
  input  logic          uv_lock,
  input  logic          sense_zc,
  input  logic [CW-1:0] half_norm,
  input  logic [CW-1:0] half_strike,
  input  logic [CW-1:0] half_floor,
  input  logic [CW-1:0] ovl_dem,
  output logic          gate_a,
  output logic          gate_b,
  output logic          gate_c,
  output logic          gate_d
);
  localparam int N_LEG = 2;

  logic             enable;
  logic             ph_main;
  logic             ph_lag;
  logic [N_LEG-1:0] leg_run;
  logic [N_LEG-1:0] leg_want;
  leg_drv_t         leg_drv [N_LEG];

  assign enable = !uv_lock && (strike || burst_on);

  psb_ramp #(.CW(CW), .OVN(OVN), .OVS(OVS)) ramp_i (
    .clk         (clk),
    .rst         (rst),
    .run         (enable),
    .strike      (strike),
    .zc          (sense_zc),
    .half_norm   (half_norm),
    .half_strike (half_strike),
    .half_floor  (half_floor),
    .dem         (ovl_dem),
    .ph_main     (ph_main),
    .ph_lag      (ph_lag)
  );

  // leg 0 follows the main phase; leg 1 the inverted lagged phase
  assign leg_run[0]  = enable;
  assign leg_want[0] = ph_main;
  assign leg_run[1]  = enable && fb_mode;
  assign leg_want[1] = ~ph_lag;

  for (genvar g = 0; g < N_LEG; g++) begin : g_leg
    psb_deadband #(.DEAD_CYC(DEAD_CYC)) leg_i (
      .clk  (clk),
      .rst  (rst),
      .run  (leg_run[g]),
      .want (leg_want[g]),
      .drv  (leg_drv[g])
    );
  end

  assign gate_a = leg_drv[0].hi;
  assign gate_b = leg_drv[0].lo;
  assign gate_c = leg_drv[1].hi;
  assign gate_d = leg_drv[1].lo;
endmodule

// File: rtl/psb_gate_seq_chk.sv
module psb_gate_seq_chk #(
  parameter int DEAD_CYC = 6
) (
  input logic clk,
  input logic rst,
  input logic fb_mode,
  input logic strike,
  input logic burst_on,
  input logic uv_lock,
  input logic gate_a,
  input logic gate_b,
  input logic gate_c,
  input logic gate_d
);
  localparam int QW = $clog2(DEAD_CYC + 2);
  localparam logic [QW-1:0] QMAX = QW'(DEAD_CYC);

  logic [QW-1:0] gap1_q;
  logic [QW-1:0] gap2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap1_q <= '0;
      gap2_q <= '0;
    end else begin
      gap1_q <= (gate_a || gate_b) ? '0 : ((gap1_q == QMAX) ? gap1_q : gap1_q + QW'(1));
      gap2_q <= (gate_c || gate_d) ? '0 : ((gap2_q == QMAX) ? gap2_q : gap2_q + QW'(1));
    end
  end

  // R2
  leg1_excl_chk: assert property (@(posedge clk) disable iff (rst) !(gate_a && gate_b));
  // R2
  leg2_excl_chk: assert property (@(posedge clk) disable iff (rst) !(gate_c && gate_d));
  // R2
  leg1_dead_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(gate_a) || $rose(gate_b)) |-> (gap1_q == QMAX));
  // R2
  leg2_dead_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(gate_c) || $rose(gate_d)) |-> (gap2_q == QMAX));
  // R5
  pp_leg2_off_chk: assert property (@(posedge clk) disable iff (rst)
    !fb_mode |=> (!gate_c && !gate_d));
  // R9
  burst_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!strike && !burst_on) |=> !(gate_a || gate_b || gate_c || gate_d));
  // R10
  uv_off_chk: assert property (@(posedge clk) disable iff (rst)
    uv_lock |=> !(gate_a || gate_b || gate_c || gate_d));
endmodule

bind psb_gate_seq psb_gate_seq_chk #(.DEAD_CYC(DEAD_CYC)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .fb_mode  (fb_mode),
  .strike   (strike),
  .burst_on (burst_on),
  .uv_lock  (uv_lock),
  .gate_a   (gate_a),
  .gate_b   (gate_b),
  .gate_c   (gate_c),
  .gate_d   (gate_d)
);

// File: tb/psb_gate_seq_tb.sv
`timescale 1ns/1ps
module psb_gate_seq_tb_top;
  localparam int CW   = 12;
  localparam int DEAD = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fb_mode = 1'b1, strike = 1'b0, burst_on = 1'b1, uv_lock = 1'b0, sense_zc = 1'b0;
  logic [CW-1:0] half_norm = 12'd40, half_strike = 12'd25, half_floor = 12'd10, ovl_dem = 12'd20;
  logic gate_a, gate_b, gate_c, gate_d;

  int n_chk = 0;
  int n_bad = 0;
  bit chk_on = 1'b0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  psb_gate_seq #(.CW(CW), .DEAD_CYC(DEAD)) dut_i (
    .clk(clk), .rst(rst), .fb_mode(fb_mode), .strike(strike), .burst_on(burst_on),
    .uv_lock(uv_lock), .sense_zc(sense_zc), .half_norm(half_norm),
    .half_strike(half_strike), .half_floor(half_floor), .ovl_dem(ovl_dem),
    .gate_a(gate_a), .gate_b(gate_b), .gate_c(gate_c), .gate_d(gate_d)
  );

  // expected lag from R4
  function automatic int exp_lag(int h, int v);
    int vmax = (h * 115) / 128;
    int ov = (v < vmax) ? v : vmax;
    return h - ov;
  endfunction

  // reference model state (updated on each rising edge from requirement rules)
  int m_cnt = 0, m_h = 0, m_s = 0;
  bit m_ph = 0;
  bit l_side [2];
  int l_dc [2];
  bit l_hi [2];
  bit l_lo [2];

  task automatic leg_step(int i, bit run, bit want);
    if (rst) begin
      l_side[i] = 0; l_dc[i] = DEAD; l_hi[i] = 0; l_lo[i] = 0;
    end else if (!run) begin
      l_side[i] = want; l_dc[i] = DEAD; l_hi[i] = 0; l_lo[i] = 0;
    end else if (want != l_side[i]) begin
      l_side[i] = want; l_dc[i] = DEAD - 1; l_hi[i] = 0; l_lo[i] = 0;
    end else if (l_dc[i] != 0) begin
      l_dc[i]--; l_hi[i] = 0; l_lo[i] = 0;
    end else begin
      l_hi[i] = !l_side[i]; l_lo[i] = l_side[i];
    end
  endtask

  always @(posedge clk) begin
    bit en, ph2, restart;
    int hsel;
    en   = !uv_lock && (strike || burst_on);
    ph2  = (m_cnt >= m_s) ? m_ph : !m_ph;
    leg_step(0, en, m_ph);
    leg_step(1, en && fb_mode, !ph2);
    hsel = strike ? int'(half_strike) : int'(half_norm);
    restart = (m_cnt + 1 >= m_h) || (!strike && sense_zc && (m_cnt + 1 >= int'(half_floor)));
    if (rst || !en) begin
      m_cnt = 0; m_ph = 0; m_h = hsel; m_s = exp_lag(hsel, int'(ovl_dem));
    end else if (restart) begin
      m_cnt = 0; m_ph = !m_ph; m_h = hsel; m_s = exp_lag(hsel, int'(ovl_dem));
    end else begin
      m_cnt++;
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // lockstep comparison, away from the active edge
  always @(negedge clk) begin
    if (chk_on)
      check(cur_req, {gate_a, gate_b, gate_c, gate_d},
            {l_hi[0], l_lo[0], l_hi[1], l_lo[1]});
  end

  task automatic run_for(int n, string req);
    cur_req = req;
    repeat (n) @(negedge clk);
  endtask

  task automatic zc_train(int n, int every, string req);
    cur_req = req;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      sense_zc = ((k % every) == every - 1);
    end
    @(negedge clk);
    sense_zc = 1'b0;
  endtask

  // count cycles over one full period (2*h) where a condition on the gates holds
  task automatic count_win(int n, int sel, output int cnt);
    cnt = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      case (sel)
        0: cnt += int'(gate_a);
        1: cnt += int'(gate_a && gate_d);
        default: cnt += int'(gate_b && gate_c);
      endcase
    end
  endtask

  initial begin
    int first, cnt;
    void'($urandom(32'd7319));
    // R1 reset state
    repeat (4) @(negedge clk);
    check("R1 reset low", {gate_a, gate_b, gate_c, gate_d}, 0);
    chk_on = 1'b1;
    rst = 1'b0;
    first = 0;
    for (int k = 1; k <= DEAD + 4; k++) begin
      @(negedge clk);
      if (first == 0 && (gate_a || gate_b || gate_c || gate_d)) begin
        first = k;
        check("R1 first gate is A", int'(gate_a), 1);
      end
    end
    check("R1 first turn-on edge", first, DEAD + 1);

    // R3 / R4 steady full bridge, h=40, demand 20 -> overlap 20-6
    run_for(200, "R3 steady halves");
    count_win(80, 0, cnt);
    check("R3 gate_a on time", cnt, 40 - DEAD);
    count_win(80, 1, cnt);
    check("R4 A/D overlap", cnt, 20 - DEAD);
    count_win(80, 2, cnt);
    check("R4 B/C overlap", cnt, 20 - DEAD);
    // R4 demand clipped to floor(40*115/128)=35
    ovl_dem = 12'd300;
    run_for(200, "R4 clip");
    count_win(80, 1, cnt);
    check("R4 clipped overlap", cnt, 35 - DEAD);
    // R4 zero demand
    ovl_dem = 12'd0;
    run_for(200, "R4 zero");
    count_win(80, 1, cnt);
    check("R4 zero overlap", cnt, 0);
    // R11 mid-half changes
    ovl_dem = 12'd15;
    run_for(13, "R11 mid-half change");
    half_norm = 12'd52; ovl_dem = 12'd30;
    run_for(17, "R11 mid-half change");
    half_norm = 12'd33;
    run_for(300, "R11 mid-half change");
    // tiny half period below the dead time
    half_norm = 12'd3;
    run_for(60, "R2 short half");
    half_norm = 12'd40; ovl_dem = 12'd20;
    run_for(150, "R3 steady halves");
    // R5 push-pull
    fb_mode = 1'b0;
    run_for(200, "R5 push-pull");
    fb_mode = 1'b1;
    run_for(100, "R5 full-bridge back");
    // R6 sync strobes after the floor
    zc_train(300, 30, "R6 zero-cross sync");
    // R7 strobes before the floor
    half_floor = 12'd20;
    zc_train(300, 5, "R7 floor clamp");
    half_floor = 12'd10;
    // R8 striking ignores sense, R9 burst ignored in striking
    strike = 1'b1; burst_on = 1'b0;
    zc_train(300, 7, "R8 striking");
    strike = 1'b0;
    run_for(50, "R9 burst off");
    burst_on = 1'b1;
    run_for(150, "R9 burst on");
    for (int k = 0; k < 6; k++) begin
      burst_on = 1'b0; run_for(7 + k * 5, "R9 burst toggling");
      burst_on = 1'b1; run_for(30 + k * 11, "R9 burst toggling");
    end
    // R10 under-voltage
    strike = 1'b1; uv_lock = 1'b1;
    run_for(60, "R10 uv lock");
    uv_lock = 1'b0; strike = 1'b0;
    run_for(150, "R10 uv release");

    // constrained random mix
    cur_req = "R2 random mix";
    for (int k = 0; k < 6000; k++) begin
      @(negedge clk);
      sense_zc = (($urandom % 7) == 0);
      if ((k % 97) == 0) begin
        fb_mode     = $urandom % 2;
        strike      = (($urandom % 5) == 0);
        burst_on    = (($urandom % 6) != 0);
        uv_lock     = (($urandom % 12) == 0);
        half_norm   = CW'(4 + $urandom % 60);
        half_strike = CW'(4 + $urandom % 40);
        half_floor  = CW'($urandom % 50);
        ovl_dem     = CW'($urandom % 80);
      end
    end
    sense_zc = 1'b0;
    run_for(5, "R2 random mix");

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule